// File: doc/BRIEF.md
# Signed-Count Shift and Rotate Unit

This unit performs every shift and rotate of an 8-bit datapath in one pass. It takes one operand, a signed shift count and the incoming carry flag. It returns the transformed byte together with new carry, zero and sign flags.

There are no separate left and right operations. The sign of the count sets the direction. One select chooses between shifting and rotating. A second mode bit picks the variant: a shift is either logical or arithmetic, and a rotate is either plain or runs through the carry.

The count comes from one of two places: a 4-bit immediate, or an 8-bit register value. The select decides which one is used. All outputs are registered, so a result appears one clock after its operands are applied.

Top module: `shrot_unit`

## Requirements
- R1: The count is a two's-complement value. When `cnt_sel_i`=0 it is the 4-bit `imm_cnt_i` sign-extended (-8..+7). When `cnt_sel_i`=1 it is the 8-bit `reg_cnt_i` (-128..+127). A positive count moves bits toward the MSB (left) and a negative count moves them toward the LSB (right).
- R2: A count of zero returns the operand unchanged and copies `carry_i` to `carry_o`. This holds for every value of `op_rot_i` and `mode_i`.
- R3: Logical shifting (`op_rot_i`=0, `mode_i`=0) fills vacated bits with zeros. `carry_o` is the last bit shifted out. A magnitude of 8 gives a zero result, with `carry_o` equal to the bit at the far edge. A magnitude of 9 or more gives a zero result and a zero carry.
- R4: An arithmetic right shift (`op_rot_i`=0, `mode_i`=1, negative count) fills with copies of operand bit 7, and `carry_o` is the last bit shifted out. A magnitude of 8 or more gives all copies of bit 7. Above 8, the carry equals bit 7.
- R5: An arithmetic left shift (`op_rot_i`=0, `mode_i`=1, positive count) gives the same result and carry as a logical left shift.
- R6: A plain rotate (`op_rot_i`=1, `mode_i`=0) rotates the byte by the magnitude modulo 8. `carry_o` is the bit that wrapped last: result bit 0 for a left rotate, result bit 7 for a right rotate. This holds even when the magnitude is a nonzero multiple of 8.
- R7: A rotate through carry (`op_rot_i`=1, `mode_i`=1) rotates the 9-bit ring {carry, byte} by the magnitude modulo 9. The ring's top bit becomes `carry_o`.
- R8: `zero_o` is 1 exactly when the 8-bit result is zero, and `sign_o` equals result bit 7.
- R9: Outputs reflect the inputs present at the previous rising clock edge. A synchronous active-high `rst` clears the result and all flags to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| operand_i | input | 8 | Data to shift or rotate |
| carry_i | input | 1 | Incoming carry flag |
| op_rot_i | input | 1 | 0 = shift, 1 = rotate |
| mode_i | input | 1 | Shift: 0 logical, 1 arithmetic. Rotate: 0 plain, 1 through carry |
| cnt_sel_i | input | 1 | 0 = immediate count, 1 = register count |
| imm_cnt_i | input | 4 | Signed short immediate count |
| reg_cnt_i | input | 8 | Signed register count |
| result_o | output | 8 | Registered result byte |
| carry_o | output | 1 | Registered carry out |
| zero_o | output | 1 | Registered zero flag |
| sign_o | output | 1 | Registered sign flag |

## Verification
The unit has exactly one register stage between operands and outputs. Every result and flag is therefore due at the first rising edge after the inputs settle. The bench drives each vector on a falling edge, lets one rising edge pass, and compares all four outputs at the following falling edge, before the next vector is applied.

Expected values come from a model that moves the data one bit position at a time, as many times as the count magnitude, rather than in one wide shift. Saturation and modulo behaviour therefore fall out of that loop, not out of a formula shared with the design. The sweep covers all 256 operands, both carry values, every immediate count, and a register count list that straddles 8, 9 and the extreme values.

// File: rtl/shrot_pkg.sv
package shrot_pkg;

  typedef enum logic [1:0] {
    SR_SHIFT_LOG = 2'b00,
    SR_SHIFT_ARI = 2'b01,
    SR_ROT_PLAIN = 2'b10,
    SR_ROT_CARRY = 2'b11
  } sr_kind_e;

  function automatic sr_kind_e sr_kind(input logic rot, input logic mode);
    return sr_kind_e'({rot, mode});
  endfunction

endpackage

// File: rtl/shrot_cnt_dec.sv
module shrot_cnt_dec #(
  parameter int IMM_W = 4,
  parameter int CNT_W = 8
) (
  input  logic             cnt_sel_i,
  input  logic [IMM_W-1:0] imm_cnt_i,
  input  logic [CNT_W-1:0] reg_cnt_i,
  output logic             left_o,
  output logic             nonzero_o,
  output logic [CNT_W-1:0] mag_o
);

  localparam int EXT_W = CNT_W - IMM_W;

  logic [CNT_W-1:0] eff;
  logic             neg;

  always_comb begin
    if (cnt_sel_i) eff = reg_cnt_i;
    else           eff = {{EXT_W{imm_cnt_i[IMM_W-1]}}, imm_cnt_i};
    neg       = eff[CNT_W-1];
    nonzero_o = |eff;
    left_o    = !neg && nonzero_o;
    mag_o     = neg ? (~eff + 1'b1) : eff;
  end

endmodule

// File: rtl/shrot_shift_path.sv
module shrot_shift_path #(
  parameter int W     = 8,
  parameter int CNT_W = 8
) (
  input  logic [W-1:0]     data_i,
  input  logic             arith_i,
  input  logic             left_i,
  input  logic [CNT_W-1:0] mag_i,
  output logic [W-1:0]     data_o,
  output logic             carry_o
);

  localparam int SH_W = $clog2(W + 2);

  logic [SH_W-1:0]   amt;
  logic [W:0]        lwide;
  logic signed [W:0] rwide;

  always_comb begin
    if (mag_i > CNT_W'(W)) amt = SH_W'(W + 1);
    else                   amt = SH_W'(mag_i);
    lwide = {1'b0, data_i} << amt;
    if (arith_i) rwide = $signed({data_i, 1'b0}) >>> amt;
    else         rwide = $signed({data_i, 1'b0}) >> amt;
    if (left_i) begin
      data_o  = lwide[W-1:0];
      carry_o = lwide[W];
    end else begin
      data_o  = rwide[W:1];
      carry_o = rwide[0];
    end
  end

endmodule

// File: rtl/shrot_rot_path.sv
module shrot_rot_path #(
  parameter int W         = 8,
  parameter int CNT_W     = 8,
  parameter bit INC_CARRY = 1'b0
) (
  input  logic [W-1:0]     data_i,
  input  logic             carry_i,
  input  logic             left_i,
  input  logic [CNT_W-1:0] mag_i,
  output logic [W-1:0]     data_o,
  output logic             carry_o
);

  localparam int RING = W + (INC_CARRY ? 1 : 0);
  localparam int R_W  = $clog2(RING + 1);

  logic [RING-1:0]   ring;
  logic [R_W-1:0]    k;
  logic [R_W-1:0]    kl;
  logic [2*RING-1:0] dbl;
  logic [RING-1:0]   rot;

  generate
    if (INC_CARRY) begin : g_ring_c
      assign ring = {carry_i, data_i};
    end else begin : g_ring_p
      assign ring = data_i;
    end
  endgenerate

  always_comb begin
    k = R_W'(mag_i % CNT_W'(RING));
    if (left_i || k == '0) kl = k;
    else                   kl = R_W'(RING) - k;
    dbl = {ring, ring} << kl;
    rot = dbl[2*RING-1 -: RING];
  end

  assign data_o = rot[W-1:0];

  generate
    if (INC_CARRY) begin : g_cy_c
      assign carry_o = rot[RING-1];
    end else begin : g_cy_p
      assign carry_o = left_i ? rot[0] : rot[W-1];
    end
  endgenerate

endmodule

// File: rtl/shrot_unit.sv
module shrot_unit
  import shrot_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int IMM_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] operand_i,
  input  logic              carry_i,
  input  logic              op_rot_i,
  input  logic              mode_i,
  input  logic              cnt_sel_i,
  input  logic [IMM_W-1:0]  imm_cnt_i,
  input  logic [DATA_W-1:0] reg_cnt_i,
  output logic [DATA_W-1:0] result_o,
  output logic              carry_o,
  output logic              zero_o,
  output logic              sign_o
);

  localparam int CNT_W = DATA_W;

  logic              left, nonzero;
  logic [CNT_W-1:0]  mag;
  logic [DATA_W-1:0] sh_data;
  logic              sh_cy;
  logic [DATA_W-1:0] rt_data [2];
  logic              rt_cy   [2];
  logic [DATA_W-1:0] nxt_data;
  logic              nxt_cy;
  sr_kind_e          kind;

  shrot_cnt_dec #(.IMM_W(IMM_W), .CNT_W(CNT_W)) u_dec (
    .cnt_sel_i (cnt_sel_i),
    .imm_cnt_i (imm_cnt_i),
    .reg_cnt_i (reg_cnt_i),
    .left_o    (left),
    .nonzero_o (nonzero),
    .mag_o     (mag)
  );

  shrot_shift_path #(.W(DATA_W), .CNT_W(CNT_W)) u_shift (
    .data_i  (operand_i),
    .arith_i (mode_i),
    .left_i  (left),
    .mag_i   (mag),
    .data_o  (sh_data),
    .carry_o (sh_cy)
  );

  for (genvar gi = 0; gi < 2; gi++) begin : g_rot
    shrot_rot_path #(.W(DATA_W), .CNT_W(CNT_W), .INC_CARRY(gi == 1)) u_rot (
      .data_i  (operand_i),
      .carry_i (carry_i),
      .left_i  (left),
      .mag_i   (mag),
      .data_o  (rt_data[gi]),
      .carry_o (rt_cy[gi])
    );
  end

  always_comb begin
    kind = sr_kind(op_rot_i, mode_i);
    unique case (kind)
      SR_ROT_PLAIN: begin nxt_data = rt_data[0]; nxt_cy = rt_cy[0]; end
      SR_ROT_CARRY: begin nxt_data = rt_data[1]; nxt_cy = rt_cy[1]; end
      default:      begin nxt_data = sh_data;    nxt_cy = sh_cy;    end
    endcase
    if (!nonzero) begin
      nxt_data = operand_i;
      nxt_cy   = carry_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result_o <= '0;
      carry_o  <= 1'b0;
      zero_o   <= 1'b0;
      sign_o   <= 1'b0;
    end else begin
      result_o <= nxt_data;
      carry_o  <= nxt_cy;
      zero_o   <= ~|nxt_data;
      sign_o   <= nxt_data[DATA_W-1];
    end
  end

endmodule

// File: rtl/shrot_unit_chk.sv
module shrot_unit_chk #(
  parameter int DATA_W = 8,
  parameter int IMM_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [DATA_W-1:0] operand_i,
  input logic              carry_i,
  input logic              op_rot_i,
  input logic              mode_i,
  input logic              cnt_sel_i,
  input logic [IMM_W-1:0]  imm_cnt_i,
  input logic [DATA_W-1:0] reg_cnt_i,
  input logic [DATA_W-1:0] result_o,
  input logic              carry_o,
  input logic              zero_o,
  input logic              sign_o
);

  logic              primed;
  logic [DATA_W-1:0] cnt;
  logic [DATA_W-1:0] mag;

  always_ff @(posedge clk) primed <= !rst;

  always_comb begin
    cnt = cnt_sel_i ? reg_cnt_i : {{(DATA_W-IMM_W){imm_cnt_i[IMM_W-1]}}, imm_cnt_i};
    mag = cnt[DATA_W-1] ? (~cnt + 1'b1) : cnt;
  end

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (result_o == '0 && !carry_o && !zero_o && !sign_o)); // R9
  AST_LEFT_BY_ONE: assert property (@(posedge clk) disable iff (rst)
    (primed && !op_rot_i && cnt == DATA_W'(1)) |=> (result_o == {$past(operand_i[DATA_W-2:0]), 1'b0})); // R1
  AST_ZERO_COUNT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (primed && cnt == '0) |=> (result_o == $past(operand_i) && carry_o == $past(carry_i))); // R2
  AST_LOGIC_SATURATES: assert property (@(posedge clk) disable iff (rst)
    (primed && !op_rot_i && !mode_i && mag > DATA_W'(DATA_W)) |=> (result_o == '0 && !carry_o)); // R3
  AST_ARITH_SATURATES: assert property (@(posedge clk) disable iff (rst)
    (primed && !op_rot_i && mode_i && cnt[DATA_W-1] && mag > DATA_W'(DATA_W))
      |=> (result_o == {DATA_W{$past(operand_i[DATA_W-1])}} && carry_o == $past(operand_i[DATA_W-1]))); // R4
  AST_ROT_KEEPS_ONES: assert property (@(posedge clk) disable iff (rst)
    (primed && op_rot_i && !mode_i) |=> ($countones(result_o) == $countones($past(operand_i)))); // R6
  AST_RING_KEEPS_ONES: assert property (@(posedge clk) disable iff (rst)
    (primed && op_rot_i && mode_i) |=> ($countones({carry_o, result_o}) == $countones({$past(carry_i), $past(operand_i)}))); // R7
  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (rst)
    primed |-> (zero_o == (result_o == '0))); // R8
  AST_SIGN_FLAG: assert property (@(posedge clk) disable iff (rst)
    primed |-> (sign_o == result_o[DATA_W-1])); // R8

endmodule

bind shrot_unit shrot_unit_chk #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_chk (.*);

// File: tb/shrot_unit_tb_top.sv
module shrot_unit_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] operand_i = '0;
  logic       carry_i = 1'b0;
  logic       op_rot_i = 1'b0;
  logic       mode_i = 1'b0;
  logic       cnt_sel_i = 1'b0;
  logic [3:0] imm_cnt_i = '0;
  logic [7:0] reg_cnt_i = '0;
  logic [7:0] result_o;
  logic       carry_o, zero_o, sign_o;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  shrot_unit dut_i (
    .clk(clk), .rst(rst), .operand_i(operand_i), .carry_i(carry_i),
    .op_rot_i(op_rot_i), .mode_i(mode_i), .cnt_sel_i(cnt_sel_i),
    .imm_cnt_i(imm_cnt_i), .reg_cnt_i(reg_cnt_i),
    .result_o(result_o), .carry_o(carry_o), .zero_o(zero_o), .sign_o(sign_o)
  );

  // step-by-step model: one bit position per loop pass
  task automatic model(input logic [7:0] d_in, input logic c_in, input logic rot,
                       input logic md, input int cnt,
                       output logic [7:0] d, output logic c);
    int m;
    logic t;
    d = d_in; c = c_in;
    m = (cnt < 0) ? -cnt : cnt;
    for (int i = 0; i < m; i++) begin
      if (cnt > 0) begin
        t = d[7];
        if (!rot)    d = {d[6:0], 1'b0};
        else if (md) d = {d[6:0], c};
        else         d = {d[6:0], d[7]};
        c = t;
      end else begin
        t = d[0];
        if (!rot)    d = {md ? d[7] : 1'b0, d[7:1]};
        else if (md) d = {c, d[7:1]};
        else         d = {d[0], d[7:1]};
        c = t;
      end
    end
  endtask

  function automatic string req_of(input logic rot, input logic md, input int cnt);
    if (cnt == 0) return "R2";
    if (rot) return md ? "R7" : "R6";
    if (!md) return "R3";
    return (cnt > 0) ? "R5" : "R4";
  endfunction

  task automatic run_vec(input logic [7:0] d, input logic ci, input logic rot,
                         input logic md, input logic sel, input logic [3:0] imm,
                         input logic [7:0] rc, input string tag);
    int cnt;
    logic [7:0] ed;
    logic ec;
    cnt = sel ? int'($signed(rc)) : int'($signed(imm));
    model(d, ci, rot, md, cnt, ed, ec);
    operand_i = d; carry_i = ci; op_rot_i = rot; mode_i = md;
    cnt_sel_i = sel; imm_cnt_i = imm; reg_cnt_i = rc;
    @(posedge clk);
    @(negedge clk);
    total++;
    if (result_o !== ed || carry_o !== ec) begin
      bad++;
      $display("FAIL %s %s cnt=%0d op=%02h ci=%0b rot=%0b md=%0b: got %02h/%0b exp %02h/%0b",
               tag, req_of(rot, md, cnt), cnt, d, ci, rot, md, result_o, carry_o, ed, ec);
    end
    total++;
    if (zero_o !== (ed == 8'h00) || sign_o !== ed[7]) begin
      bad++;
      $display("FAIL R8 flags: got z=%0b s=%0b exp z=%0b s=%0b",
               zero_o, sign_o, ed == 8'h00, ed[7]);
    end
  endtask

  task automatic check_reset(input string when);
    total++;
    if (result_o !== 8'h00 || carry_o !== 1'b0 || zero_o !== 1'b0 || sign_o !== 1'b0) begin
      bad++;
      $display("FAIL R9 reset %s: got %02h/%0b/%0b/%0b exp 00/0/0/0",
               when, result_o, carry_o, zero_o, sign_o);
    end
  endtask

  localparam logic [7:0] REG_CNTS [12] = '{8'h80, 8'hF7, 8'hF8, 8'hF9, 8'hFF, 8'h00,
                                           8'h01, 8'h07, 8'h08, 8'h09, 8'h11, 8'h7F};

  initial begin
    repeat (3) @(negedge clk);
    check_reset("initial");
    rst = 1'b0;
    // R1: immediate sign extension and direction
    run_vec(8'h80, 1'b0, 1'b0, 1'b0, 1'b0, 4'b1000, 8'h00, "R1 imm -8 right");
    run_vec(8'h01, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0111, 8'h00, "R1 imm +7 left");
    run_vec(8'h81, 1'b1, 1'b0, 1'b1, 1'b1, 4'b0000, 8'hFE, "R1 reg -2 arith");
    // R9: mid-run reset clears registered outputs
    operand_i = 8'hFF; op_rot_i = 1'b1; mode_i = 1'b0; cnt_sel_i = 1'b0; imm_cnt_i = 4'h3;
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    check_reset("mid-run");
    rst = 1'b0;
    // immediate sweep: R2..R8
    for (int k = 0; k < 4; k++)
      for (int ci = 0; ci < 2; ci++)
        for (int im = 0; im < 16; im++)
          for (int d = 0; d < 256; d++)
            run_vec(8'(d), 1'(ci), 1'(k >> 1), 1'(k), 1'b0, 4'(im), 8'h00, "imm");
    // register sweep across saturation and modulo edges
    for (int k = 0; k < 4; k++)
      for (int ci = 0; ci < 2; ci++)
        for (int j = 0; j < 12; j++)
          for (int d = 0; d < 256; d++)
            run_vec(8'(d), 1'(ci), 1'(k >> 1), 1'(k), 1'b1, 4'h0, REG_CNTS[j], "reg");
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule